// File: doc/BRIEF.md
# Monochrome Text-Mode VGA Generator

This block drives a 640x480, 60 Hz VGA monitor from a 25.175 MHz pixel clock and shows a screen of 64 columns by 48 rows of 8x8-pixel monochrome characters. It owns the sync counters and reads a 4K-byte video memory through a read-only synchronous port with one cycle of read latency. Character codes sit in the lower 3K of that memory. An 8-byte-per-glyph font for 128 codes sits in the upper 1K, starting at byte 3072.

For every character cell the block issues two reads. The first returns the character code. The second returns the font byte for the current glyph line. That byte enters an 8-bit shift register at the exact moment the previous character's last pixel leaves it. Each text row is 8 glyph lines followed by 2 generated dark lines, so 48 rows cover 480 lines. The 512-pixel text field is centred with dark borders. The memory is read every frame and never held, so new codes and glyphs appear on the next frame.

Top module: `vga_text_gen`

## Requirements
- R1: While reset is asserted, hsync_n_o and vsync_n_o are high and pix_o is low.
- R2: A line lasts 800 clocks, counted 0 to 799. hsync_n_o is low exactly for line positions 656 to 751. All outputs appear one clock after the counter position they describe.
- R3: A frame lasts 525 lines, counted 0 to 524. vsync_n_o is low exactly during lines 490 and 491.
- R4: The cell at text row r, column c is drawn from the code at memory byte r*64 + c.
- R5: The glyph line g of code k is read from byte 3072 + (k mod 128)*8 + g. Bit 7 of the code has no effect.
- R6: Font byte 0 gives the top glyph line. Within a byte, bit 7 is the leftmost pixel and bit 0 the rightmost.
- R7: Lines 8 and 9 of every 10-line text row are dark, whatever the memory holds.
- R8: pix_o is low outside line positions 64 to 575, and during lines 480 to 524.
- R9: A change to codes or glyphs written during vertical blanking appears in full on the next frame, with sync timing unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock, 25.175 MHz |
| rst_ni | input | 1 | Active-low synchronous reset |
| mem_addr_o | output | 12 | Video memory read address, updated every clock |
| mem_rdata_i | input | 8 | Read data, valid one clock after the address |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| pix_o | output | 1 | Monochrome pixel, high is lit |

## Verification
A slip in the fetch phase shows on pix_o within the first text line after reset. The glyph bits then appear shifted by whole pixels or taken from the wrong byte. If the line-in-row tracker runs out of step, the dark separator lines land on the wrong scanlines within the first 10 lines of a frame. A wrong sync counter is visible in hsync_n_o within one line and in vsync_n_o within one frame. The bench compares all three outputs on every clock against a model built from the memory image, so any of these faults shows at the first affected pixel.

// File: rtl/vga_text_pkg.sv
package vga_text_pkg;
   localparam int unsigned GLYPH_W    = 8;
   localparam int unsigned FONT_CODES = 128;

   typedef struct packed {
      logic hsync_n;
      logic vsync_n;
      logic pix;
   } vid_out_t;
endpackage

// File: rtl/vtg_axis_counter.sv
module vtg_axis_counter #(
   parameter int unsigned VIS  = 640,
   parameter int unsigned FP   = 16,
   parameter int unsigned SYNC = 96,
   parameter int unsigned BP   = 48,
   localparam int unsigned TOTAL = VIS + FP + SYNC + BP,
   localparam int unsigned W     = $clog2(TOTAL)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         step_i,
   output logic [W-1:0] pos_o,
   output logic         last_o,
   output logic         sync_o,
   output logic         vis_o
);
   localparam logic [W-1:0] LAST_POS = W'(TOTAL - 1);
   localparam logic [W-1:0] SYNC_LO  = W'(VIS + FP);
   localparam logic [W-1:0] SYNC_HI  = W'(VIS + FP + SYNC);
   localparam logic [W-1:0] VIS_END  = W'(VIS);

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     pos_o <= '0;
      else if (step_i) pos_o <= last_o ? '0 : pos_o + 1'b1;
   end

   assign last_o = (pos_o == LAST_POS);
   assign sync_o = (pos_o >= SYNC_LO) && (pos_o < SYNC_HI);
   assign vis_o  = (pos_o < VIS_END);
endmodule

// File: rtl/vtg_row_tracker.sv
module vtg_row_tracker #(
   parameter int unsigned ROWS    = 48,
   parameter int unsigned GLYPH_H = 8,
   parameter int unsigned GAP     = 2,
   localparam int unsigned ROW_H  = GLYPH_H + GAP,
   localparam int unsigned RW     = $clog2(ROWS + 1),
   localparam int unsigned GW     = $clog2(ROW_H)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          line_end_i,
   input  logic          frame_end_i,
   input  logic          vis_line_i,
   output logic [RW-1:0] row_o,
   output logic [GW-1:0] gline_o,
   output logic          glyph_line_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni || frame_end_i) begin
         row_o   <= '0;
         gline_o <= '0;
      end else if (line_end_i && vis_line_i) begin
         if (gline_o == GW'(ROW_H - 1)) begin
            gline_o <= '0;
            row_o   <= row_o + 1'b1;
         end else begin
            gline_o <= gline_o + 1'b1;
         end
      end
   end

   assign glyph_line_o = (gline_o < GW'(GLYPH_H));
endmodule

// File: rtl/vtg_fetch.sv
module vtg_fetch #(
   parameter int unsigned COLS      = 64,
   parameter int unsigned GLYPH_H   = 8,
   parameter int unsigned FONT_BASE = 3072,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned LEFT      = 64,
   parameter int unsigned H_W       = 10,
   parameter int unsigned RW        = 6,
   parameter int unsigned GW        = 4,
   localparam int unsigned CW       = $clog2(COLS),
   localparam int unsigned WIN_LO   = LEFT - 8,
   localparam int unsigned WIN_HI   = LEFT - 8 + 8 * COLS
) (
   input  logic [H_W-1:0]    h_pos_i,
   input  logic [RW-1:0]     row_i,
   input  logic [GW-1:0]     gline_i,
   input  logic [7:0]        rdata_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              capture_o,
   output logic              load_o
);
   logic [H_W-1:0]    slot_pos;
   logic              in_win;
   logic [2:0]        phase;
   logic [CW-1:0]     col;
   logic [ADDR_W-1:0] char_addr;
   logic [ADDR_W-1:0] font_addr;

   assign slot_pos = h_pos_i - H_W'(WIN_LO);
   assign in_win   = (h_pos_i >= H_W'(WIN_LO)) && (h_pos_i < H_W'(WIN_HI));
   assign phase    = slot_pos[2:0];
   assign col      = slot_pos[CW+2:3];

   generate
      if ((COLS & (COLS - 1)) == 0) begin : g_pow2_cols
         assign char_addr = ADDR_W'({row_i, col});
      end else begin : g_mul_cols
         assign char_addr = ADDR_W'(row_i) * ADDR_W'(COLS) + ADDR_W'(col);
      end
   endgenerate

   assign font_addr = ADDR_W'(FONT_BASE) + ADDR_W'(rdata_i[6:0]) * ADDR_W'(GLYPH_H)
                      + ADDR_W'(gline_i);

   assign addr_o    = (in_win && phase == 3'd1) ? font_addr : char_addr;
   assign capture_o = in_win && (phase == 3'd2);
   assign load_o    = in_win && (phase == 3'd7);
endmodule

// File: rtl/vtg_shifter.sv
module vtg_shifter
   import vga_text_pkg::*;
(
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               capture_i,
   input  logic               load_i,
   input  logic [GLYPH_W-1:0] rdata_i,
   output logic               msb_o
);
   logic [GLYPH_W-1:0] hold_q;
   logic [GLYPH_W-1:0] shift_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hold_q  <= '0;
         shift_q <= '0;
      end else begin
         if (capture_i) hold_q <= rdata_i;
         if (load_i)    shift_q <= hold_q;
         else           shift_q <= {shift_q[GLYPH_W-2:0], 1'b0};
      end
   end

   assign msb_o = shift_q[GLYPH_W-1];
endmodule

// File: rtl/vga_text_gen.sv
module vga_text_gen
   import vga_text_pkg::*;
#(
   parameter int unsigned H_VIS     = 640,
   parameter int unsigned H_FP      = 16,
   parameter int unsigned H_SYNC    = 96,
   parameter int unsigned H_BP      = 48,
   parameter int unsigned V_VIS     = 480,
   parameter int unsigned V_FP      = 10,
   parameter int unsigned V_SYNC    = 2,
   parameter int unsigned V_BP      = 33,
   parameter int unsigned COLS      = 64,
   parameter int unsigned ROWS      = 48,
   parameter int unsigned GLYPH_H   = 8,
   parameter int unsigned GAP       = 2,
   parameter int unsigned LEFT      = 64,
   parameter int unsigned FONT_BASE = 3072,
   parameter int unsigned ADDR_W    = 12,
   localparam int unsigned H_TOT    = H_VIS + H_FP + H_SYNC + H_BP,
   localparam int unsigned V_TOT    = V_VIS + V_FP + V_SYNC + V_BP,
   localparam int unsigned H_W      = $clog2(H_TOT),
   localparam int unsigned V_W      = $clog2(V_TOT),
   localparam int unsigned ROW_H    = GLYPH_H + GAP,
   localparam int unsigned RW       = $clog2(ROWS + 1),
   localparam int unsigned GW       = $clog2(ROW_H)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [7:0]        mem_rdata_i,
   output logic              hsync_n_o,
   output logic              vsync_n_o,
   output logic              pix_o
);
   if (LEFT < 8 || LEFT + GLYPH_W * COLS > H_VIS) begin : g_bad_left
      $error("text field does not fit the visible line");
   end
   if (ROWS * ROW_H > V_VIS) begin : g_bad_rows
      $error("text rows do not fit the visible frame");
   end
   if (COLS < 2 || FONT_BASE < COLS * ROWS) begin : g_bad_cols
      $error("character area overlaps the font table");
   end
   if (FONT_BASE + FONT_CODES * GLYPH_H > (1 << ADDR_W)) begin : g_bad_font
      $error("font table exceeds the address space");
   end

   logic [H_W-1:0] h_pos;
   logic [V_W-1:0] v_pos;
   logic h_last, h_sync, h_vis;
   logic v_last, v_sync, v_vis;
   logic [RW-1:0] row;
   logic [GW-1:0] gline;
   logic glyph_line, capture, load, msb, text_en;
   vid_out_t vid_q;

   vtg_axis_counter #(.VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)) u_hcnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .step_i(1'b1),
      .pos_o(h_pos), .last_o(h_last), .sync_o(h_sync), .vis_o(h_vis));

   vtg_axis_counter #(.VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)) u_vcnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .step_i(h_last),
      .pos_o(v_pos), .last_o(v_last), .sync_o(v_sync), .vis_o(v_vis));

   vtg_row_tracker #(.ROWS(ROWS), .GLYPH_H(GLYPH_H), .GAP(GAP)) u_rows (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_end_i(h_last),
      .frame_end_i(h_last && v_last), .vis_line_i(v_vis),
      .row_o(row), .gline_o(gline), .glyph_line_o(glyph_line));

   vtg_fetch #(.COLS(COLS), .GLYPH_H(GLYPH_H), .FONT_BASE(FONT_BASE), .ADDR_W(ADDR_W),
               .LEFT(LEFT), .H_W(H_W), .RW(RW), .GW(GW)) u_fetch (
      .h_pos_i(h_pos), .row_i(row), .gline_i(gline), .rdata_i(mem_rdata_i),
      .addr_o(mem_addr_o), .capture_o(capture), .load_o(load));

   vtg_shifter u_shift (
      .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(capture), .load_i(load),
      .rdata_i(mem_rdata_i), .msb_o(msb));

   assign text_en = h_vis && v_vis && glyph_line
                    && (h_pos >= H_W'(LEFT)) && (h_pos < H_W'(LEFT + GLYPH_W * COLS));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) vid_q <= '{hsync_n: 1'b1, vsync_n: 1'b1, pix: 1'b0};
      else         vid_q <= '{hsync_n: ~h_sync, vsync_n: ~v_sync, pix: text_en & msb};
   end

   assign hsync_n_o = vid_q.hsync_n;
   assign vsync_n_o = vid_q.vsync_n;
   assign pix_o     = vid_q.pix;
endmodule

// File: rtl/vga_text_gen_chk.sv
module vga_text_gen_chk #(
   parameter int unsigned H_VIS     = 640,
   parameter int unsigned H_FP      = 16,
   parameter int unsigned H_SYNC    = 96,
   parameter int unsigned H_TOT     = 800,
   parameter int unsigned V_VIS     = 480,
   parameter int unsigned V_FP      = 10,
   parameter int unsigned V_SYNC    = 2,
   parameter int unsigned COLS      = 64,
   parameter int unsigned ROWS      = 48,
   parameter int unsigned GLYPH_H   = 8,
   parameter int unsigned ROW_H     = 10,
   parameter int unsigned LEFT      = 64,
   parameter int unsigned FONT_BASE = 3072,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned H_W       = 10,
   parameter int unsigned V_W       = 10
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              hsync_n_o,
   input logic              vsync_n_o,
   input logic              pix_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [H_W-1:0]    h_pos,
   input logic [V_W-1:0]    v_pos
);
   int unsigned hh, vv, rel;
   logic h_in_sync, v_in_sync, in_cols, on_glyph, fetch_win;
   always_comb begin
      hh        = int'(h_pos);
      vv        = int'(v_pos);
      rel       = hh + 8 - LEFT;
      h_in_sync = (hh >= H_VIS + H_FP) && (hh < H_VIS + H_FP + H_SYNC);
      v_in_sync = (vv >= V_VIS + V_FP) && (vv < V_VIS + V_FP + V_SYNC);
      in_cols   = (hh >= LEFT) && (hh < LEFT + 8 * COLS) && (vv < V_VIS);
      on_glyph  = (vv % ROW_H) < GLYPH_H;
      fetch_win = (hh + 8 >= LEFT) && (rel < 8 * COLS) && (vv < ROWS * ROW_H);
   end

   AST_HSYNC_PLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hsync_n_o |-> $past(h_in_sync));                                   // R2
   AST_HPOS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(h_pos) < H_TOT);                                               // R2
   AST_VSYNC_PLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vsync_n_o |-> $past(v_in_sync));                                   // R3
   AST_CHAR_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_win && rel % 8 == 0) |-> int'(mem_addr_o) < COLS * ROWS);    // R4
   AST_FONT_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_win && rel % 8 == 1) |-> int'(mem_addr_o) >= FONT_BASE);     // R5
   AST_GAP_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pix_o |-> $past(on_glyph));                                         // R7
   AST_BORDER_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pix_o |-> $past(in_cols));                                          // R8
endmodule

bind vga_text_gen vga_text_gen_chk #(
   .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_TOT(H_TOT),
   .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .COLS(COLS), .ROWS(ROWS),
   .GLYPH_H(GLYPH_H), .ROW_H(ROW_H), .LEFT(LEFT), .FONT_BASE(FONT_BASE),
   .ADDR_W(ADDR_W), .H_W(H_W), .V_W(V_W)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o),
   .pix_o(pix_o), .mem_addr_o(mem_addr_o), .h_pos(h_pos), .v_pos(v_pos)
);

// File: tb/vga_text_gen_tb_top.sv
module vga_text_gen_tb_top;
   localparam int CLK_PERIOD_NS = 40;
   localparam int HV = 48, HF = 4, HS = 8, HB = 4, HT = HV + HF + HS + HB;
   localparam int VV = 30, VF = 2, VS = 2, VB = 3, VT = VV + VF + VS + VB;
   localparam int COLS = 4, ROWS = 3, LEFT = 8, FBASE = 3072;
   localparam int FRAME = HT * VT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD_NS / 2) clk = ~clk;

   logic [11:0] addr;
   logic [7:0]  rdata;
   logic [7:0]  mem [4096];
   logic hs_n, vs_n, pix;

   always @(posedge clk) rdata <= mem[addr];

   vga_text_gen #(
      .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
      .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
      .COLS(COLS), .ROWS(ROWS), .LEFT(LEFT), .FONT_BASE(FBASE)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(addr), .mem_rdata_i(rdata),
      .hsync_n_o(hs_n), .vsync_n_o(vs_n), .pix_o(pix));

   typedef struct {
      logic  hs, vs, px;
      string tag;
   } exp_t;

   exp_t q[$];
   int n_run = 0, n_fail = 0;
   int idx = 0;
   bit done = 1'b0;

   task automatic check(input string tag, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at t=%0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   task automatic fill_codes(input int seed);
      for (int a = 0; a < COLS * ROWS; a++) mem[a] = 8'((a * 37 + 133 + seed * 91) & 255);
   endtask

   function automatic exp_t model(input int i);
      exp_t e;
      int h, v, fr, x, ln;
      logic [7:0] c, b;
      h = i % HT; v = (i / HT) % VT; fr = i / FRAME;
      e.hs = !(h >= HV + HF && h < HV + HF + HS);
      e.vs = !(v >= VV + VF && v < VV + VF + VS);
      e.px = 1'b0;
      e.tag = "R8";
      if (v < VV && h >= LEFT && h < LEFT + 8 * COLS) begin
         ln = v % 10;
         if (ln >= 8) e.tag = "R7";
         else begin
            x = h - LEFT;
            c = mem[(v / 10) * COLS + x / 8];
            b = mem[FBASE + int'(c[6:0]) * 8 + ln];
            e.px = b[7 - x % 8];
            e.tag = (fr >= 2) ? "R9 R4 R5 R6" : "R4 R5 R6";
         end
      end
      return e;
   endfunction

   // driver: one expected item per clock once reset is released
   always @(posedge clk) begin
      if (rst_n && !done) begin
         q.push_back(model(idx));
         idx++;
      end
   end

   // monitor: compare away from the active edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check({"R2 hsync ", e.tag}, hs_n, e.hs);
         check({"R3 vsync ", e.tag}, vs_n, e.vs);
         check({"pixel ", e.tag}, pix, e.px);
      end
   end

   initial begin
      for (int a = 0; a < 4096; a++) mem[a] = 8'((a * 29 + 11) & 255);
      fill_codes(0);
      repeat (4) @(negedge clk);
      check("R1 hsync idle in reset", hs_n, 1'b1);
      check("R1 vsync idle in reset", vs_n, 1'b1);
      check("R1 pixel dark in reset", pix, 1'b0);
      rst_n = 1'b1;
      wait (idx >= FRAME + HT * (VV + VF + 1));
      @(negedge clk);
      fill_codes(1);
      for (int a = FBASE; a < FBASE + 64; a++) mem[a] = ~mem[a];
      wait (idx >= 3 * FRAME);
      done = 1'b1;
      repeat (3) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD_NS * 50000);
      n_fail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule